// File: doc/BRIEF.md
# Display Raster Timing Generator

This block produces the raster timing for one display pipe, running entirely on the pixel clock. Software programs the frame geometry through a small word-addressed register port: total and active pixel counts per line, total and active line counts per frame, and the start and end positions of both sync pulses. From these the block drives horizontal sync, vertical sync, a data-enable strobe for the active picture and a one-cycle vblank pulse. It also tells the fetch engine which of two framebuffer base addresses to scan out and which burst size to use.

A control word holds an active-low run bit that acts as a soft reset, an output enable, a page-flip request, a burst-size code and an interrupt enable. Clearing the run bit parks the scan counters at the origin and clears the frame counter, but keeps every timing and address setting. Clearing output enable silences the video outputs while the counters keep running, so the frame counter and the vblank pulse continue. A flip request waits for the next vblank start, swaps the base address and then clears itself. A sticky vblank status bit, cleared by writing one, feeds the interrupt output through its enable.

The scan is controlled by a three-state machine. SCAN_HOLD: counters held at (0,0), outputs low; it moves to SCAN_ACTIVE one clock after the run bit reads 1 (transition "release"). SCAN_ACTIVE: lines 0 to active-1; at the end of the last active line it moves to SCAN_VBLANK (transition "enter blanking"). SCAN_VBLANK: the remaining lines; at the end of the last line of the frame it returns to SCAN_ACTIVE (transition "wrap"). From either running state a run bit of 0 returns it to SCAN_HOLD (transition "soft reset").

Top module: `crtc_timing_gen`

## Requirements
- R1: Word 1 holds the line length (total pixels in bits 31:16, active pixels in bits 15:0) and word 2 the frame height in lines in the same layout; while running, the horizontal count steps 0..total-1 on each clock and the line count 0..total-1 once per line, and `de` is high exactly when the horizontal count is below the active pixels and the line count is below the active lines.
- R2: Word 3 holds the hsync end in bits 31:16, an enable in bit 15 and the start in bits 14:0; `hsync` is high when enabled and start <= horizontal count < end. Word 4 has the same layout for `vsync`, compared with the line count.
- R3: Reading word 7 returns the live horizontal count in bits 31:16 and the live line count in bits 15:0.
- R4: Bit 0 of the control word (word 0) is an active-low soft reset: while it is 0 the counters sit at (0,0) and `de`, `hsync`, `vsync` and `vblank_pulse` stay low; one clock after it becomes 1 the scan starts at (0,0) and advances by one pixel per clock.
- R5: A soft reset clears the scan counters and the frame counter and leaves the timing words, the base addresses and the current base selection unchanged.
- R6: `vblank_pulse` is high for one clock at pixel 0 of the first line after the last active line, and the 32-bit frame counter (read at word 8) increments at that moment, also while output is disabled.
- R7: Control bit 1 is output enable; while it is 0 `de`, `hsync` and `vsync` are low and the counters, the frame counter and `vblank_pulse` keep running.
- R8: Writing 1 to control bit 2 requests a flip: at the next vblank pulse `fb_base` swaps between word 5 and word 6; bit 2 reads 1 until then and 0 afterwards. After hardware reset `fb_base` shows word 5.
- R9: Word 9 bit 0 is a vblank status bit set by each vblank pulse and cleared by writing 1 to it; `irq` is that bit ANDed with control bit 8.
- R10: Control bits 5:4 select the fetch burst: code 0, 1, 2, 3 gives 32, 64, 128, 256 bytes on `fetch_burst_bytes`.
- R11: After hardware reset every register reads 0, so the scan is held, all video outputs and `irq` are low, `fb_base` is 0 and the burst is 32 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, the only clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word index for writes |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register word index for reads |
| rd_data | output | 32 | Register read data (combinational) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active picture strobe |
| vblank_pulse | output | 1 | One-clock pulse at start of vertical blanking |
| irq | output | 1 | Vblank interrupt request |
| fb_base | output | 32 | Base address of the framebuffer being scanned out |
| fetch_burst_bytes | output | 9 | Fetch burst size in bytes |

## Verification
The bench builds the block with its default parameters: 16-bit timing fields, 32-bit register data, a 4-bit register index and a 32-byte minimum burst. It programs a tiny 8-by-6 raster with 5-by-4 active, so one frame takes 48 clocks and dozens of frames, several page flips, interrupt cycles and soft resets fit in a short run. A reference model of the counters, which reads the bench's own register writes, is compared with the outputs on every clock. A queue of expected base addresses checks the swap that follows each vblank pulse.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    localparam int FIELD_W = 16;
    localparam int DATA_W  = 32;

    // word indices of the register port
    localparam int IDX_CTRL  = 0;
    localparam int IDX_HTIME = 1;
    localparam int IDX_VTIME = 2;
    localparam int IDX_HSYNC = 3;
    localparam int IDX_VSYNC = 4;
    localparam int IDX_FB0   = 5;
    localparam int IDX_FB1   = 6;
    localparam int IDX_SCAN  = 7;
    localparam int IDX_VBCNT = 8;
    localparam int IDX_IRQ   = 9;

    // control word bit positions
    localparam int CTRL_RUN_BIT   = 0;
    localparam int CTRL_OE_BIT    = 1;
    localparam int CTRL_FLIP_BIT  = 2;
    localparam int CTRL_BURST_LSB = 4;
    localparam int CTRL_BURST_W   = 2;
    localparam int CTRL_IRQEN_BIT = 8;
    localparam logic [DATA_W-1:0] CTRL_STORE_MASK = 32'h0000_0133;

    // sync word: enable bit, start below it, end in upper half
    localparam int SYNC_EN_BIT = 15;

    typedef enum logic [1:0] {
        SCAN_HOLD   = 2'd0,
        SCAN_ACTIVE = 2'd1,
        SCAN_VBLANK = 2'd2
    } scan_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] h_total;
        logic [FIELD_W-1:0] h_active;
        logic [FIELD_W-1:0] v_total;
        logic [FIELD_W-1:0] v_active;
        logic [FIELD_W-1:0] hs_start;
        logic [FIELD_W-1:0] hs_end;
        logic [FIELD_W-1:0] vs_start;
        logic [FIELD_W-1:0] vs_end;
        logic               hs_en;
        logic               vs_en;
    } timing_t;

endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
    import crtc_pkg::*;
#(
    parameter int REG_AW = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [REG_AW-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [REG_AW-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    vblank_pulse_i,
    input  logic [FIELD_W-1:0]      h_i,
    input  logic [FIELD_W-1:0]      v_i,
    input  logic [DATA_W-1:0]       vbcnt_i,
    output timing_t                 timing_o,
    output logic                    run_o,
    output logic                    oe_o,
    output logic [CTRL_BURST_W-1:0] burst_code_o,
    output logic                    irq_o,
    output logic [DATA_W-1:0]       fb_base_o
);

    localparam int NUM_FB = 2;

    logic [DATA_W-1:0]             ctrl_q;
    logic [DATA_W-1:0]             htime_q;
    logic [DATA_W-1:0]             vtime_q;
    logic [DATA_W-1:0]             hsync_q;
    logic [DATA_W-1:0]             vsync_q;
    logic [NUM_FB-1:0][DATA_W-1:0] fb_q;
    logic                          flip_pend_q;
    logic                          fb_sel_q;
    logic                          vb_status_q;

    logic wr_ctrl;
    logic wr_irq;

    always_comb begin
        wr_ctrl = wr_en && (wr_addr == REG_AW'(IDX_CTRL));
        wr_irq  = wr_en && (wr_addr == REG_AW'(IDX_IRQ));
    end

    // plain storage words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            htime_q <= '0;
            vtime_q <= '0;
            hsync_q <= '0;
            vsync_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_AW'(IDX_CTRL))  ctrl_q  <= wr_data & CTRL_STORE_MASK;
            if (wr_addr == REG_AW'(IDX_HTIME)) htime_q <= wr_data;
            if (wr_addr == REG_AW'(IDX_VTIME)) vtime_q <= wr_data;
            if (wr_addr == REG_AW'(IDX_HSYNC)) hsync_q <= wr_data;
            if (wr_addr == REG_AW'(IDX_VSYNC)) vsync_q <= wr_data;
        end
    end

    // framebuffer base words, one per buffer
    for (genvar g = 0; g < NUM_FB; g++) begin : g_fb
        always_ff @(posedge clk) begin
            if (!rst_n)
                fb_q[g] <= '0;
            else if (wr_en && (wr_addr == REG_AW'(IDX_FB0 + g)))
                fb_q[g] <= wr_data;
        end
    end

    // flip request: set by software, retired at vblank start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flip_pend_q <= 1'b0;
            fb_sel_q    <= 1'b0;
        end else begin
            if (vblank_pulse_i && flip_pend_q)
                fb_sel_q <= ~fb_sel_q;
            if (wr_ctrl && wr_data[CTRL_FLIP_BIT])
                flip_pend_q <= 1'b1;
            else if (vblank_pulse_i)
                flip_pend_q <= 1'b0;
        end
    end

    // sticky vblank status, write one to clear, new event wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            vb_status_q <= 1'b0;
        else if (vblank_pulse_i)
            vb_status_q <= 1'b1;
        else if (wr_irq && wr_data[0])
            vb_status_q <= 1'b0;
    end

    always_comb begin
        timing_o.h_total  = htime_q[2*FIELD_W-1:FIELD_W];
        timing_o.h_active = htime_q[FIELD_W-1:0];
        timing_o.v_total  = vtime_q[2*FIELD_W-1:FIELD_W];
        timing_o.v_active = vtime_q[FIELD_W-1:0];
        timing_o.hs_end   = hsync_q[2*FIELD_W-1:FIELD_W];
        timing_o.hs_start = {1'b0, hsync_q[SYNC_EN_BIT-1:0]};
        timing_o.hs_en    = hsync_q[SYNC_EN_BIT];
        timing_o.vs_end   = vsync_q[2*FIELD_W-1:FIELD_W];
        timing_o.vs_start = {1'b0, vsync_q[SYNC_EN_BIT-1:0]};
        timing_o.vs_en    = vsync_q[SYNC_EN_BIT];
        run_o        = ctrl_q[CTRL_RUN_BIT];
        oe_o         = ctrl_q[CTRL_OE_BIT];
        burst_code_o = ctrl_q[CTRL_BURST_LSB +: CTRL_BURST_W];
        irq_o        = vb_status_q && ctrl_q[CTRL_IRQEN_BIT];
        fb_base_o    = fb_q[fb_sel_q];
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_AW'(IDX_CTRL):  rd_data = ctrl_q | (DATA_W'(flip_pend_q) << CTRL_FLIP_BIT);
            REG_AW'(IDX_HTIME): rd_data = htime_q;
            REG_AW'(IDX_VTIME): rd_data = vtime_q;
            REG_AW'(IDX_HSYNC): rd_data = hsync_q;
            REG_AW'(IDX_VSYNC): rd_data = vsync_q;
            REG_AW'(IDX_FB0):   rd_data = fb_q[0];
            REG_AW'(IDX_FB1):   rd_data = fb_q[1];
            REG_AW'(IDX_SCAN):  rd_data = {h_i, v_i};
            REG_AW'(IDX_VBCNT): rd_data = vbcnt_i;
            REG_AW'(IDX_IRQ):   rd_data = DATA_W'(vb_status_q);
            default:            rd_data = '0;
        endcase
    end

    // a pending flip only retires on a vblank pulse
    assert_flip_at_vblank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flip_pend_q) |-> $past(vblank_pulse_i));

    // status only rises because of a vblank pulse
    assert_status_on_vblank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vb_status_q) |-> $past(vblank_pulse_i));

endmodule

// File: rtl/crtc_scan_fsm.sv
module crtc_scan_fsm
    import crtc_pkg::*;
#(
    parameter int VB_W = DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [FIELD_W-1:0] h_total_i,
    input  logic [FIELD_W-1:0] v_total_i,
    input  logic [FIELD_W-1:0] v_active_i,
    output logic [FIELD_W-1:0] h_o,
    output logic [FIELD_W-1:0] v_o,
    output logic               active_o,
    output logic               vblank_pulse_o,
    output logic [VB_W-1:0]    vbcnt_o
);

    scan_state_e state_q, state_d;
    logic [FIELD_W-1:0] h_q, v_q;
    logic [VB_W-1:0]    vbcnt_q;
    logic line_end, frame_end, last_active_line;

    always_comb begin
        line_end         = (h_q >= h_total_i - 1'b1);
        frame_end        = (v_q >= v_total_i - 1'b1);
        last_active_line = ((v_q + 1'b1) >= v_active_i);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_HOLD: begin
                if (run_i) state_d = SCAN_ACTIVE;
            end
            SCAN_ACTIVE: begin
                if (!run_i)                             state_d = SCAN_HOLD;
                else if (line_end && last_active_line)  state_d = SCAN_VBLANK;
            end
            SCAN_VBLANK: begin
                if (!run_i)                      state_d = SCAN_HOLD;
                else if (line_end && frame_end)  state_d = SCAN_ACTIVE;
            end
            default: state_d = SCAN_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SCAN_HOLD;
        else        state_q <= state_d;
    end

    // raster counters
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || state_q == SCAN_HOLD) begin
            h_q <= '0;
            v_q <= '0;
        end else if (line_end) begin
            h_q <= '0;
            v_q <= frame_end ? '0 : v_q + 1'b1;
        end else begin
            h_q <= h_q + 1'b1;
        end
    end

    // frame counter, cleared only by reset or soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            vbcnt_q <= '0;
        else if (vblank_pulse_o)
            vbcnt_q <= vbcnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        active_o       = (state_q != SCAN_HOLD);
        vblank_pulse_o = (state_q == SCAN_VBLANK) && (h_q == '0) && (v_q == v_active_i);
        h_o            = h_q;
        v_o            = v_q;
        vbcnt_o        = vbcnt_q;
    end

    assert_soft_reset_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (h_q == '0 && v_q == '0 && vbcnt_q == '0));

    assert_vbcount_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_pulse_o && run_i) |=> (vbcnt_q == $past(vbcnt_q) + 1'b1));

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_pulse_o |=> !vblank_pulse_o);

    assert_hold_parks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCAN_HOLD) |-> (h_q == '0 && v_q == '0 && !vblank_pulse_o));

endmodule

// File: rtl/crtc_sync_out.sv
module crtc_sync_out
    import crtc_pkg::*;
(
    input  logic    oe_i,
    input  logic    active_i,
    input  logic [FIELD_W-1:0] h_i,
    input  logic [FIELD_W-1:0] v_i,
    input  logic [FIELD_W-1:0] h_active_i,
    input  logic [FIELD_W-1:0] v_active_i,
    input  logic [FIELD_W-1:0] hs_start_i,
    input  logic [FIELD_W-1:0] hs_end_i,
    input  logic               hs_en_i,
    input  logic [FIELD_W-1:0] vs_start_i,
    input  logic [FIELD_W-1:0] vs_end_i,
    input  logic               vs_en_i,
    output logic de_o,
    output logic hsync_o,
    output logic vsync_o
);

    logic live;

    always_comb begin
        live    = oe_i && active_i;
        de_o    = live && (h_i < h_active_i) && (v_i < v_active_i);
        hsync_o = live && hs_en_i && (h_i >= hs_start_i) && (h_i < hs_end_i);
        vsync_o = live && vs_en_i && (v_i >= vs_start_i) && (v_i < vs_end_i);
    end

endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
    import crtc_pkg::*;
#(
    parameter int REG_AW    = 4,
    parameter int BURST_MIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              vblank_pulse,
    output logic              irq,
    output logic [31:0]       fb_base,
    output logic [$clog2(BURST_MIN*8):0] fetch_burst_bytes
);

    localparam int BURST_W = $clog2(BURST_MIN * 8) + 1;

    timing_t                 cfg;
    logic                    run, oe;
    logic [CTRL_BURST_W-1:0] burst_code;
    logic [FIELD_W-1:0]      h_cnt, v_cnt;
    logic                    active;
    logic [DATA_W-1:0]       vbcnt;

    crtc_regs #(.REG_AW(REG_AW)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .rd_addr        (rd_addr),
        .rd_data        (rd_data),
        .vblank_pulse_i (vblank_pulse),
        .h_i            (h_cnt),
        .v_i            (v_cnt),
        .vbcnt_i        (vbcnt),
        .timing_o       (cfg),
        .run_o          (run),
        .oe_o           (oe),
        .burst_code_o   (burst_code),
        .irq_o          (irq),
        .fb_base_o      (fb_base)
    );

    crtc_scan_fsm #(.VB_W(DATA_W)) u_scan (
        .clk            (clk),
        .rst_n          (rst_n),
        .run_i          (run),
        .h_total_i      (cfg.h_total),
        .v_total_i      (cfg.v_total),
        .v_active_i     (cfg.v_active),
        .h_o            (h_cnt),
        .v_o            (v_cnt),
        .active_o       (active),
        .vblank_pulse_o (vblank_pulse),
        .vbcnt_o        (vbcnt)
    );

    crtc_sync_out u_sync (
        .oe_i       (oe),
        .active_i   (active),
        .h_i        (h_cnt),
        .v_i        (v_cnt),
        .h_active_i (cfg.h_active),
        .v_active_i (cfg.v_active),
        .hs_start_i (cfg.hs_start),
        .hs_end_i   (cfg.hs_end),
        .hs_en_i    (cfg.hs_en),
        .vs_start_i (cfg.vs_start),
        .vs_end_i   (cfg.vs_end),
        .vs_en_i    (cfg.vs_en),
        .de_o       (de),
        .hsync_o    (hsync),
        .vsync_o    (vsync)
    );

    // burst size doubles with each code step
    assign fetch_burst_bytes = BURST_W'(BURST_MIN) << burst_code;

    // data-enable only inside the active line range
    assert_de_inside_R1: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (v_cnt < cfg.v_active && active));

endmodule

// File: tb/crtc_timing_gen_tb.sv
module crtc_timing_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        hsync, vsync, de, vblank_pulse, irq;
    logic [31:0] fb_base;
    logic [8:0]  fetch_burst_bytes;

    always #2.5 clk = ~clk;

    crtc_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .hsync(hsync), .vsync(vsync), .de(de),
        .vblank_pulse(vblank_pulse), .irq(irq), .fb_base(fb_base),
        .fetch_burst_bytes(fetch_burst_bytes)
    );

    localparam logic [31:0] FB_A = 32'h1000_0000;
    localparam logic [31:0] FB_B = 32'h2000_4000;

    int checks = 0, failures = 0;
    bit done = 0, chk_on = 0, hs_seen = 0, fb_due = 0;
    logic [31:0] cur_ctrl = '0, exp_fb = '0, rv;
    logic [31:0] fb_exp_q[$];

    // reference model, fed from the bench's own writes
    int m_htot, m_hact, m_vtot, m_vact, m_hss, m_hse, m_vss, m_vse;
    int m_h, m_v;
    bit m_hsen, m_vsen, m_run, m_oe, m_act;
    logic [31:0] m_vb;
    bit exp_pulse;

    assign exp_pulse = m_act && m_h == 0 && m_v == m_vact;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run <= 0; m_oe <= 0; m_htot <= 0; m_hact <= 0; m_vtot <= 0; m_vact <= 0;
            m_hss <= 0; m_hse <= 0; m_vss <= 0; m_vse <= 0; m_hsen <= 0; m_vsen <= 0;
        end else if (wr_en) begin
            case (wr_addr)
                4'd0: begin m_run <= wr_data[0]; m_oe <= wr_data[1]; end
                4'd1: begin m_htot <= int'(wr_data[31:16]); m_hact <= int'(wr_data[15:0]); end
                4'd2: begin m_vtot <= int'(wr_data[31:16]); m_vact <= int'(wr_data[15:0]); end
                4'd3: begin m_hse <= int'(wr_data[31:16]); m_hss <= int'(wr_data[14:0]); m_hsen <= wr_data[15]; end
                4'd4: begin m_vse <= int'(wr_data[31:16]); m_vss <= int'(wr_data[14:0]); m_vsen <= wr_data[15]; end
                default: ;
            endcase
        end
    end

    always @(posedge clk) begin
        if (!rst_n || !m_run) begin
            m_act <= 0; m_h <= 0; m_v <= 0; m_vb <= '0;
        end else if (!m_act) begin
            m_act <= 1;
        end else begin
            if (exp_pulse) m_vb <= m_vb + 1;
            if (m_h == m_htot - 1) begin
                m_h <= 0;
                m_v <= (m_v == m_vtot - 1) ? 0 : m_v + 1;
            end else begin
                m_h <= m_h + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison of the video outputs with the model
    always @(negedge clk) begin
        if (chk_on && rst_n) begin
            logic [3:0] e, a;
            e[3] = m_oe && m_act && m_h < m_hact && m_v < m_vact;
            e[2] = m_oe && m_act && m_hsen && m_h >= m_hss && m_h < m_hse;
            e[1] = m_oe && m_act && m_vsen && m_v >= m_vss && m_v < m_vse;
            e[0] = exp_pulse;
            a = {de, hsync, vsync, vblank_pulse};
            chk(a == e, "R1/R2/R4/R6/R7 de-hs-vs-pulse", {28'd0, a}, {28'd0, e});
        end
        if (hsync) hs_seen = 1;
    end

    // scoreboard for the base address after each vblank pulse
    always @(negedge clk) begin
        if (fb_due) chk(fb_base == exp_fb, "R8 fb_base after vblank", fb_base, exp_fb);
        fb_due = chk_on && vblank_pulse;
        if (chk_on && vblank_pulse && fb_exp_q.size() > 0) exp_fb = fb_exp_q.pop_front();
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_pulse();
        @(negedge clk);
        while (!vblank_pulse) @(negedge clk);
    endtask

    task automatic push_flip(input logic [31:0] target);
        fb_exp_q.push_back(target);
        wr(4'd0, cur_ctrl | 32'h4);
    endtask

    initial begin
        logic [31:0] vb0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk({de, hsync, vsync, vblank_pulse, irq} == 5'd0, "R11 outputs low", {27'd0, de, hsync, vsync, vblank_pulse, irq}, 0);
        chk(fb_base == 0, "R11 fb_base", fb_base, 0);
        chk(fetch_burst_bytes == 9'd32, "R11/R10 burst default", {23'd0, fetch_burst_bytes}, 32);
        rd(4'd0, rv); chk(rv == 0, "R11 ctrl reads 0", rv, 0);
        rd(4'd8, rv); chk(rv == 0, "R11 frame count 0", rv, 0);

        // 8x6 raster, 5x4 active, hsync 5..6, vsync line 4
        wr(4'd1, (32'd8 << 16) | 32'd5);
        wr(4'd2, (32'd6 << 16) | 32'd4);
        wr(4'd3, (32'd7 << 16) | 32'h8000 | 32'd5);
        wr(4'd4, (32'd5 << 16) | 32'h8000 | 32'd4);
        wr(4'd5, FB_A);
        wr(4'd6, FB_B);
        exp_fb = FB_A;
        chk(fb_base == FB_A, "R8 fb_base shows word 5", fb_base, FB_A);
        rd(4'd7, rv); chk(rv == 0, "R4 held at origin", rv, 0);
        chk_on = 1;

        cur_ctrl = 32'h3;
        wr(4'd0, cur_ctrl);
        rd(4'd7, rv); chk(rv == 32'h0, "R4 scan starts at origin", rv, 0);
        rd(4'd7, rv); chk(rv == 32'h0001_0000, "R4 scan advances", rv, 32'h0001_0000);

        for (int k = 0; k < 6; k++) begin
            repeat (7 + 3 * k) @(negedge clk);
            rd(4'd7, rv);
            chk(rv == {m_h[15:0], m_v[15:0]}, "R3 scan position", rv, {m_h[15:0], m_v[15:0]});
        end
        repeat (150) @(negedge clk);
        rd(4'd8, rv); chk(rv == m_vb && rv >= 3, "R6 frame count", rv, m_vb);

        // output disabled: outputs quiet, frames still counted
        cur_ctrl = 32'h1;
        wr(4'd0, cur_ctrl);
        rd(4'd8, vb0);
        repeat (110) @(negedge clk);
        rd(4'd8, rv); chk(rv == m_vb && rv >= vb0 + 2, "R7/R6 counting while disabled", rv, m_vb);
        cur_ctrl = 32'h3;
        wr(4'd0, cur_ctrl);

        // hsync enable cleared
        wr(4'd3, (32'd7 << 16) | 32'd5);
        @(negedge clk); hs_seen = 0;
        repeat (60) @(negedge clk);
        chk(hs_seen == 0, "R2 hsync disabled", {31'd0, hs_seen}, 0);
        wr(4'd3, (32'd7 << 16) | 32'h8000 | 32'd5);
        hs_seen = 0;
        repeat (60) @(negedge clk);
        chk(hs_seen == 1, "R2 hsync enabled", {31'd0, hs_seen}, 1);

        // burst codes
        for (int c = 0; c < 4; c++) begin
            wr(4'd0, cur_ctrl | (32'(c) << 4));
            @(negedge clk);
            chk(fetch_burst_bytes == (9'd32 << c), "R10 burst size", {23'd0, fetch_burst_bytes}, 32'd32 << c);
        end
        wr(4'd0, cur_ctrl);

        // page flips
        wait_pulse(); repeat (2) @(negedge clk);
        push_flip(FB_B);
        rd(4'd0, rv); chk(rv[2] == 1'b1, "R8 flip pending", rv, cur_ctrl | 32'h4);
        chk(fb_base == FB_A, "R8 no swap before vblank", fb_base, FB_A);
        wait_pulse(); repeat (2) @(negedge clk);
        rd(4'd0, rv); chk(rv == cur_ctrl, "R8 flip bit self-clears", rv, cur_ctrl);
        chk(fb_base == FB_B, "R8 swapped to word 6", fb_base, FB_B);
        push_flip(FB_A);
        wait_pulse(); repeat (2) @(negedge clk);
        chk(fb_base == FB_A, "R8 swapped back to word 5", fb_base, FB_A);

        // interrupt status and gating
        wait_pulse(); repeat (2) @(negedge clk);
        rd(4'd9, rv); chk(rv == 1, "R9 status set", rv, 1);
        chk(irq == 0, "R9 irq gated off", {31'd0, irq}, 0);
        wr(4'd9, 32'h1);
        rd(4'd9, rv); chk(rv == 0, "R9 write one clears", rv, 0);
        cur_ctrl = cur_ctrl | 32'h100;
        wr(4'd0, cur_ctrl);
        chk(irq == 0, "R9 irq low while status clear", {31'd0, irq}, 0);
        wait_pulse(); @(negedge clk);
        chk(irq == 1, "R9 irq raised", {31'd0, irq}, 1);
        wr(4'd9, 32'h1);
        @(negedge clk);
        chk(irq == 0, "R9 irq dropped after clear", {31'd0, irq}, 0);

        // soft reset keeps settings
        wait_pulse(); repeat (3) @(negedge clk);
        cur_ctrl = cur_ctrl & ~32'h1;
        wr(4'd0, cur_ctrl);
        rd(4'd7, rv); chk(rv == 0, "R5 scan cleared", rv, 0);
        rd(4'd8, rv); chk(rv == 0, "R5 frame count cleared", rv, 0);
        rd(4'd1, rv); chk(rv == ((32'd8 << 16) | 32'd5), "R5 timing kept", rv, (32'd8 << 16) | 32'd5);
        rd(4'd6, rv); chk(rv == FB_B, "R5 address kept", rv, FB_B);
        chk(fb_base == FB_A, "R5 selection kept", fb_base, FB_A);
        repeat (20) @(negedge clk);
        rd(4'd7, rv); chk(rv == 0, "R4 held while run bit 0", rv, 0);
        cur_ctrl = cur_ctrl | 32'h1;
        wr(4'd0, cur_ctrl);
        repeat (60) @(negedge clk);
        rd(4'd8, rv); chk(rv == 1 && rv == m_vb, "R5/R6 count restarts", rv, 1);

        chk_on = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule